// File: doc/BRIEF.md
# Endpoint FIFO Segment Allocator

This block hands out space in a packet FIFO that several device endpoints share. The FIFO is divided into equal 512-byte units, and an internal occupancy bitmap marks each unit as free or taken. Endpoint setup logic issues an allocation request with the endpoint's maximum packet size and a slot count. The allocator sizes the grant from these two values and searches the bitmap from unit 0 upward for the first contiguous run of free units that is large enough. It then marks that run as taken and reports the byte address and the size of the grant.

A release request carries a FIFO byte address and a byte size, and clears the units that this range covers. One instance serves the transmit FIFO and a second instance serves the receive FIFO. A limit input caps how many bitmap units the search may use, so a smaller physical FIFO can share the same design.

Top module: `fifo_seg_alloc`

## Requirements
- R1: After reset, busy_o, done_o and fail_o are low and every unit is free, so the first request that fits is granted at base_i.
- R2: The grant size is (alloc_slot_i + 1) times alloc_maxp_i rounded up to a power of two, where 0 and 1 round to 1. The unit count is that size divided by 512, rounded up.
- R3: The grant starts at the lowest unit index that begins a free run of the required length. grant_addr_o equals base_i + start * 512.
- R4: An accepted request raises busy_o in the next cycle. The search examines one unit per cycle, so done_o pulses for exactly one cycle, start + units cycles after acceptance, in the same cycle that busy_o falls.
- R5: When no run fits, done_o and fail_o pulse together limit + 1 cycles after acceptance, and no unit changes.
- R6: No unit at an index equal to or above min(limit_i, 128) is ever granted.
- R7: A release clears the units from (free_addr_i - base_i) / 512 for ceil(free_size_i / 512) units, with a minimum of one. Releasing units that are already free has no effect.
- R8: When a release and an allocation request are accepted in the same cycle, the release applies first and the search sees the freed units.
- R9: Allocation and release requests that arrive while busy_o is high are ignored.
- R10: grant_addr_o and grant_size_o hold the last successful grant until the next successful grant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| base_i | input | 32 | Byte address of FIFO unit 0 |
| limit_i | input | 8 | Number of units the search may use |
| alloc_req_i | input | 1 | Allocation request, taken when idle |
| alloc_maxp_i | input | 11 | Endpoint maximum packet size in bytes |
| alloc_slot_i | input | 2 | Slot count minus one |
| free_req_i | input | 1 | Release request, taken when idle |
| free_addr_i | input | 32 | Byte address of the region to release |
| free_size_i | input | 14 | Byte size of the region to release |
| busy_o | output | 1 | Search in progress |
| done_o | output | 1 | One-cycle end-of-search pulse |
| fail_o | output | 1 | No fit, valid with done_o |
| grant_addr_o | output | 32 | Byte address of the last grant |
| grant_size_o | output | 14 | Byte size of the last grant |

## Verification
A release and an allocation can be accepted in the same idle cycle. The bench drives both requests on one edge, with the release covering the lowest units and the allocation sized so that it fits only if those units are free. The expected result comes from a behavioural bitmap that applies the release before it runs the first-fit search. A grant at unit 0, arriving after exactly the predicted number of cycles, shows that the release took effect first. A second case drives both requests while a search is running, and the next grant shows that both were dropped.

// File: rtl/seg_alloc_pkg.sv
package seg_alloc_pkg;

  typedef enum logic [0:0] {ST_IDLE, ST_SCAN} scan_st_e;

  // bytes -> whole units, at least one
  function automatic int unsigned units_for(int unsigned bytes, int unsigned unit_lg);
    int unsigned u;
    u = (bytes + (32'd1 << unit_lg) - 32'd1) >> unit_lg;
    return (u == 0) ? 32'd1 : u;
  endfunction

endpackage

// File: rtl/seg_size_calc.sv
module seg_size_calc #(
  parameter int MAXP_W  = 11,
  parameter int SLOT_W  = 2,
  parameter int UNIT_LG = 9,
  parameter int SIZE_W  = MAXP_W + 1 + SLOT_W
) (
  input  logic [MAXP_W-1:0] maxp_i,
  input  logic [SLOT_W-1:0] slot_i,
  output logic [SIZE_W-1:0] size_o,
  output logic [SIZE_W-1:0] units_o
);
  logic [MAXP_W:0] seg;

  always_comb begin
    seg = (MAXP_W+1)'(1);
    for (int i = 0; i < MAXP_W; i++)
      if (seg < {1'b0, maxp_i}) seg = seg << 1;
  end

  assign size_o  = SIZE_W'(seg) * (SIZE_W'(slot_i) + SIZE_W'(1));
  assign units_o = SIZE_W'(seg_alloc_pkg::units_for(32'(size_o), UNIT_LG));

endmodule

// File: rtl/seg_scan.sv
module seg_scan #(
  parameter int MAP_BITS = 128,
  parameter int IDX_W    = 7,
  parameter int NEED_W   = 14
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                start_i,
  input  logic [NEED_W-1:0]   need_i,
  input  logic [IDX_W:0]      limit_i,
  input  logic [MAP_BITS-1:0] map_i,
  output logic                busy_o,
  output logic                done_o,
  output logic                fail_o,
  output logic                set_o,
  output logic [IDX_W-1:0]    set_lo_o,
  output logic [IDX_W-1:0]    set_hi_o
);
  import seg_alloc_pkg::*;

  scan_st_e          st_q;
  logic [IDX_W:0]    idx_q, lim_q;
  logic [NEED_W-1:0] run_q, need_q, run_nx;
  logic [IDX_W-1:0]  rs_q, pos;
  logic              in_rng, used, hit, done_q, fail_q;

  assign in_rng = idx_q < lim_q;
  assign pos    = idx_q[IDX_W-1:0];
  assign used   = map_i[pos];
  assign run_nx = run_q + NEED_W'(1);
  assign hit    = (st_q == ST_SCAN) && in_rng && !used && (run_nx == need_q);

  assign set_o    = hit;
  assign set_lo_o = (run_q == '0) ? pos : rs_q;
  assign set_hi_o = pos;
  assign busy_o   = (st_q == ST_SCAN);
  assign done_o   = done_q;
  assign fail_o   = fail_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      idx_q  <= '0;
      lim_q  <= '0;
      run_q  <= '0;
      need_q <= '0;
      rs_q   <= '0;
      done_q <= 1'b0;
      fail_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      fail_q <= 1'b0;
      if (st_q == ST_IDLE) begin
        if (start_i) begin
          st_q   <= ST_SCAN;
          idx_q  <= '0;
          run_q  <= '0;
          need_q <= need_i;
          lim_q  <= (limit_i > (IDX_W+1)'(MAP_BITS)) ? (IDX_W+1)'(MAP_BITS) : limit_i;
        end
      end else if (!in_rng) begin
        st_q   <= ST_IDLE;
        done_q <= 1'b1;
        fail_q <= 1'b1;
      end else if (used) begin
        run_q <= '0;
        idx_q <= idx_q + 1'b1;
      end else if (hit) begin
        st_q   <= ST_IDLE;
        done_q <= 1'b1;
      end else begin
        if (run_q == '0) rs_q <= pos;
        run_q <= run_nx;
        idx_q <= idx_q + 1'b1;
      end
    end
  end

  p_done_pulse_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  p_fail_with_done_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fail_o |-> (done_o && !busy_o));
  p_idx_bound_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> (idx_q <= lim_q));
  p_grant_in_limit_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_o |-> ({1'b0, set_hi_o} < lim_q));

endmodule

// File: rtl/seg_map.sv
module seg_map #(
  parameter int MAP_BITS = 128,
  parameter int IDX_W    = 7,
  parameter int ADDR_W   = 32,
  parameter int NEED_W   = 14
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                set_i,
  input  logic [IDX_W-1:0]    set_lo_i,
  input  logic [IDX_W-1:0]    set_hi_i,
  input  logic                clr_i,
  input  logic [ADDR_W-1:0]   clr_lo_i,
  input  logic [NEED_W-1:0]   clr_cnt_i,
  output logic [MAP_BITS-1:0] map_o
);
  logic [MAP_BITS-1:0] map_q, set_mask, clr_mask;
  logic [ADDR_W:0]     c_lo, c_hi;

  assign c_lo = {1'b0, clr_lo_i};
  assign c_hi = c_lo + (ADDR_W+1)'(clr_cnt_i);

  always_comb begin
    for (int i = 0; i < MAP_BITS; i++) begin
      set_mask[i] = ((IDX_W+1)'(i) >= {1'b0, set_lo_i}) && ((IDX_W+1)'(i) <= {1'b0, set_hi_i});
      clr_mask[i] = ((ADDR_W+1)'(i) >= c_lo) && ((ADDR_W+1)'(i) < c_hi);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) map_q <= '0;
    else if (clr_i) map_q <= map_q & ~clr_mask;
    else if (set_i) map_q <= map_q | set_mask;
  end

  assign map_o = map_q;

  p_set_only_free_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |-> ((map_q & set_mask) == '0));
  p_no_free_in_scan_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(set_i && clr_i));
  p_clear_exact_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> ((map_q & $past(clr_mask)) == '0));

endmodule

// File: rtl/fifo_seg_alloc.sv
module fifo_seg_alloc #(
  parameter int UNIT_LG  = 9,
  parameter int MAP_BITS = 128,
  parameter int ADDR_W   = 32,
  parameter int MAXP_W   = 11,
  parameter int SLOT_W   = 2,
  localparam int IDX_W   = $clog2(MAP_BITS),
  localparam int SIZE_W  = MAXP_W + 1 + SLOT_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [IDX_W:0]    limit_i,
  input  logic              alloc_req_i,
  input  logic [MAXP_W-1:0] alloc_maxp_i,
  input  logic [SLOT_W-1:0] alloc_slot_i,
  input  logic              free_req_i,
  input  logic [ADDR_W-1:0] free_addr_i,
  input  logic [SIZE_W-1:0] free_size_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              fail_o,
  output logic [ADDR_W-1:0] grant_addr_o,
  output logic [SIZE_W-1:0] grant_size_o
);
  logic [SIZE_W-1:0]   req_size, req_units, size_q, free_units;
  logic [MAP_BITS-1:0] map;
  logic                accept, free_go, set;
  logic [IDX_W-1:0]    set_lo, set_hi;
  logic [ADDR_W-1:0]   free_off, addr_q;
  logic [SIZE_W-1:0]   gsize_q;

  assign accept     = alloc_req_i && !busy_o;
  assign free_go    = free_req_i && !busy_o;
  assign free_off   = free_addr_i - base_i;
  assign free_units = SIZE_W'(seg_alloc_pkg::units_for(32'(free_size_i), UNIT_LG));

  seg_size_calc #(.MAXP_W(MAXP_W), .SLOT_W(SLOT_W), .UNIT_LG(UNIT_LG), .SIZE_W(SIZE_W)) i_size (
    .maxp_i (alloc_maxp_i),
    .slot_i (alloc_slot_i),
    .size_o (req_size),
    .units_o(req_units)
  );

  seg_scan #(.MAP_BITS(MAP_BITS), .IDX_W(IDX_W), .NEED_W(SIZE_W)) i_scan (
    .clk_i, .rst_ni,
    .start_i (accept),
    .need_i  (req_units),
    .limit_i (limit_i),
    .map_i   (map),
    .busy_o  (busy_o),
    .done_o  (done_o),
    .fail_o  (fail_o),
    .set_o   (set),
    .set_lo_o(set_lo),
    .set_hi_o(set_hi)
  );

  seg_map #(.MAP_BITS(MAP_BITS), .IDX_W(IDX_W), .ADDR_W(ADDR_W), .NEED_W(SIZE_W)) i_map (
    .clk_i, .rst_ni,
    .set_i    (set),
    .set_lo_i (set_lo),
    .set_hi_i (set_hi),
    .clr_i    (free_go),
    .clr_lo_i (free_off >> UNIT_LG),
    .clr_cnt_i(free_units),
    .map_o    (map)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      size_q  <= '0;
      addr_q  <= '0;
      gsize_q <= '0;
    end else begin
      if (accept) size_q <= req_size;
      if (set) begin
        addr_q  <= base_i + (ADDR_W'(set_lo) << UNIT_LG);
        gsize_q <= size_q;
      end
    end
  end

  assign grant_addr_o = addr_q;
  assign grant_size_o = gsize_q;

  p_fail_keeps_map_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fail_o |-> $stable(map));
  p_busy_ends_in_done_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> done_o);
  p_grant_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !set |=> $stable(grant_addr_o));

endmodule

// File: tb/test_fifo_seg_alloc.sv
`timescale 1ns/1ps
module test_fifo_seg_alloc;
  localparam int BASE = 32'h0001_0000;

  logic        clk = 1'b0, rst_ni = 1'b0;
  logic [31:0] base_i = BASE;
  logic [7:0]  limit_i = 8'd128;
  logic        alloc_req_i = 1'b0, free_req_i = 1'b0;
  logic [10:0] alloc_maxp_i = '0;
  logic [1:0]  alloc_slot_i = '0;
  logic [31:0] free_addr_i = '0;
  logic [13:0] free_size_i = '0;
  logic        busy_o, done_o, fail_o;
  logic [31:0] grant_addr_o;
  logic [13:0] grant_size_o;

  int n_tests = 0, n_fail = 0;
  bit [127:0] mdl = '0;

  always #2 clk = ~clk;

  fifo_seg_alloc i_fifo_seg_alloc (
    .clk_i(clk), .rst_ni, .base_i, .limit_i, .alloc_req_i, .alloc_maxp_i, .alloc_slot_i,
    .free_req_i, .free_addr_i, .free_size_i, .busy_o, .done_o, .fail_o,
    .grant_addr_o, .grant_size_o
  );

  function automatic int pow2_up(int v);
    int p = 1;
    while (p < v) p = p * 2;
    return p;
  endfunction

  function automatic int units_of(int bytes);
    int u = (bytes + 511) / 512;
    return (u == 0) ? 1 : u;
  endfunction

  task automatic mdl_free(int addr, int size);
    int lo = (addr - BASE) / 512;
    for (int i = lo; i < lo + units_of(size); i++)
      if (i >= 0 && i < 128) mdl[i] = 1'b0;
  endtask

  task automatic check(bit ok, string req, string act, string exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%s expected=%s", req, act, exp);
    end
  endtask

  // one allocation, compared against the model on every clock
  task automatic do_alloc(int maxp, int slot, bit with_free, int f_addr, int f_size,
                          bit poke, string req);
    int size, u, lim, start, k_end, bad;
    bit found, ok;
    size  = (slot + 1) * pow2_up(maxp);
    u     = units_of(size);
    if (with_free) mdl_free(f_addr, f_size);
    lim   = (limit_i > 128) ? 128 : int'(limit_i);
    found = 1'b0;
    start = 0;
    for (int s = 0; s + u <= lim && !found; s++) begin
      bit fit = 1'b1;
      for (int j = s; j < s + u; j++) if (mdl[j]) fit = 1'b0;
      if (fit) begin found = 1'b1; start = s; end
    end
    k_end = found ? start + u : lim + 1;
    bad = 0;
    @(negedge clk);
    alloc_req_i  = 1'b1;
    alloc_maxp_i = 11'(maxp);
    alloc_slot_i = 2'(slot);
    if (with_free) begin
      free_req_i  = 1'b1;
      free_addr_i = 32'(f_addr);
      free_size_i = 14'(f_size);
    end
    @(posedge clk);
    for (int k = 0; k <= k_end + 1; k++) begin
      if (k > 0) @(posedge clk);
      @(negedge clk);
      if (k == 0) begin alloc_req_i = 1'b0; free_req_i = 1'b0; end
      if (poke && k == 1) begin
        free_req_i = 1'b1; free_addr_i = BASE; free_size_i = 14'd1024; alloc_req_i = 1'b1;
      end
      if (poke && k == 2) begin free_req_i = 1'b0; alloc_req_i = 1'b0; end
      if (k < k_end) begin
        if (!(busy_o && !done_o)) bad++;
      end else if (k == k_end) begin
        if (!(!busy_o && done_o && fail_o == !found)) bad++;
        if (found && (grant_addr_o != 32'(BASE + start * 512) || grant_size_o != 14'(size))) bad++;
      end else begin
        if (busy_o || done_o) bad++;
      end
    end
    ok = (bad == 0);
    check(ok, req,
          $sformatf("busy=%0b done=%0b fail=%0b addr=%h size=%0d mism=%0d",
                    busy_o, done_o, fail_o, grant_addr_o, grant_size_o, bad),
          $sformatf("fail=%0b addr=%h size=%0d after %0d cycles",
                    !found, BASE + start * 512, size, k_end));
    if (found) for (int j = start; j < start + u; j++) mdl[j] = 1'b1;
  endtask

  task automatic do_free(int addr, int size);
    @(negedge clk);
    free_req_i = 1'b1; free_addr_i = 32'(addr); free_size_i = 14'(size);
    @(posedge clk);
    @(negedge clk);
    free_req_i = 1'b0;
    mdl_free(addr, size);
  endtask

  initial begin
    #(4 * 200000);
    n_fail++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(!busy_o && !done_o && !fail_o, "R1 reset",
          $sformatf("%0b%0b%0b", busy_o, done_o, fail_o), "000");
    rst_ni = 1'b1;
    do_alloc(512, 1, 0, 0, 0, 0, "R1 R2 R3 first grant at base");
    do_alloc(100, 2, 0, 0, 0, 0, "R2 R4 round to 128");
    do_alloc(1024, 2, 0, 0, 0, 0, "R2 R3 six units");
    do_alloc(0, 0, 0, 0, 0, 0, "R2 zero maxp one unit");
    do_free(BASE + 2 * 512, 384);
    do_alloc(64, 0, 0, 0, 0, 0, "R7 freed hole reused");
    do_free(BASE + 100 * 512, 512);
    do_alloc(64, 0, 0, 0, 0, 0, "R7 free of free units no effect");
    do_alloc(512, 1, 1, BASE, 1024, 0, "R8 free and alloc same cycle");
    limit_i = 8'd12;
    do_alloc(1024, 1, 0, 0, 0, 0, "R5 R6 no fit under limit");
    do_alloc(16, 0, 0, 0, 0, 0, "R6 last unit under limit");
    limit_i = 8'd128;
    do_alloc(2047, 3, 0, 0, 0, 0, "R2 sixteen units");
    do_alloc(8, 0, 0, 0, 0, 1, "R9 requests during busy");
    do_alloc(8, 0, 0, 0, 0, 0, "R9 poked free was ignored");
    for (int n = 0; n < 7; n++) do_alloc(2047, 3, 0, 0, 0, 0, "R3 R5 R10 fill");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule